// File: doc/BRIEF.md
# Receive FIFO with Automatic RTS Flow Control

This block is the receive queue of a serial port. Characters arrive from the receive shift register with three error flags each. They wait in a 32-entry queue until the host reads them out. The block raises a data interrupt when the fill reaches a selectable threshold. It also drives an active-low request-to-send line that tells the far-end transmitter to pause or resume.

In automatic mode the request line follows the fill level with hysteresis. It goes high (pause) one threshold step above the programmed level. It goes low again only once reads have brought the fill down to one step below that level. Reception does not stop while the far end is paused: characters keep entering until the queue is completely full. Once full, further arrivals are dropped and flagged. An optional sticky interrupt records every automatic pause, and a clear strobe removes it.

Top module: `rx_flow_fifo`

## Requirements
- R1: The queue holds up to 32 entries of 11 bits (8 data bits plus 3 error bits) and returns them in arrival order. `fill_count` reports the number held, from 0 to 32.
- R2: Threshold select codes map to levels 0→8, 1→16, 2→24 and 3→28. `data_irq` is high exactly while `fill_count` is at or above the selected level.
- R3: While automatic mode is active, `rts_n` goes high one clock after the fill reaches the step above the selected level. That step is 16, 24, 28 or 32 for codes 0 to 3.
- R4: While automatic mode is active and paused, `rts_n` stays high above the step below the selected level. That step is 0, 8, 16 or 24 for codes 0 to 3. `rts_n` returns low one clock after the fill falls to that step.
- R5: Writes are still accepted while `rts_n` is high, as long as the queue is not full.
- R6: A write while the queue holds 32 entries, with no read in the same cycle, is discarded. Queue contents and count do not change, and `overrun` is set and stays set until reset.
- R7: A read of an empty queue leaves `fill_count` at 0 and `rd_data`/`rd_err` unchanged.
- R8: Automatic mode is active only while both `auto_rts_en` and `rts_req` are 1. Otherwise `rts_n` equals the inverse of `rts_req`.
- R9: When `rts_irq_en` is 1, each automatic pause sets `rts_irq` in the same clock that `rts_n` rises. The flag holds until a `rts_irq_clr` pulse. No flag is set when `rts_irq_en` is 0.
- R10: After reset the queue is empty, `rd_data`, `rd_err`, `data_irq`, `rts_irq` and `overrun` are 0, and the request line is not paused.
- R11: A read strobe on a non-empty queue presents the oldest entry on `rd_data`/`rd_err` one clock later and lowers `fill_count` by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Character strobe from the shift register |
| wr_data | input | 8 | Received character |
| wr_err | input | 3 | Error flags of the character |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 8 | Character last read |
| rd_err | output | 3 | Error flags of the character last read |
| fill_count | output | 6 | Entries held |
| trig_sel | input | 2 | Threshold select code |
| auto_rts_en | input | 1 | Automatic flow control enable |
| rts_req | input | 1 | Request-to-send control bit |
| rts_irq_en | input | 1 | Pause interrupt enable |
| rts_irq_clr | input | 1 | Pause interrupt clear strobe |
| data_irq | output | 1 | Fill at or above the threshold |
| rts_n | output | 1 | Active-low request to send |
| rts_irq | output | 1 | Sticky pause interrupt flag |
| overrun | output | 1 | Sticky dropped-write flag |

## Verification
A stuck or mis-decoded pause flop shows on `rts_n` one clock after the fill crosses the upper or lower step. Directed fills stop one entry short of each step and then step over it, so that error is caught within a single character. A pointer or count fault shows as out-of-order or missing characters on the next read, or as a wrong `fill_count` in the cycle after the strobe. Overrun and empty-read handling are visible at once on `overrun`, `fill_count` and the held read data.

// File: rtl/rx_flow_pkg.sv
package rx_flow_pkg;

  typedef enum logic [1:0] {
    TRIG_QUARTER = 2'd0,
    TRIG_HALF    = 2'd1,
    TRIG_3QUART  = 2'd2,
    TRIG_NEAR    = 2'd3
  } trig_sel_e;

  // Threshold for a select code, scaled from the queue depth
  function automatic int unsigned lvl_trig(int unsigned depth, logic [1:0] sel);
    case (trig_sel_e'(sel))
      TRIG_QUARTER: return depth / 4;
      TRIG_HALF:    return depth / 2;
      TRIG_3QUART:  return (3 * depth) / 4;
      default:      return depth - depth / 8;
    endcase
  endfunction

  // Step above the threshold: next code's level, or full
  function automatic int unsigned lvl_above(int unsigned depth, logic [1:0] sel);
    if (sel == 2'd3) return depth;
    return lvl_trig(depth, 2'(sel + 2'd1));
  endfunction

  // Step below the threshold: previous code's level, or empty
  function automatic int unsigned lvl_below(int unsigned depth, logic [1:0] sel);
    if (sel == 2'd0) return 0;
    return lvl_trig(depth, 2'(sel - 2'd1));
  endfunction

endpackage

// File: rtl/rx_flow_store.sv
module rx_flow_store #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned WORD_W = 11,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_word,
  output logic [CNT_W-1:0]  fill,
  output logic              wr_ok,
  output logic              rd_ok,
  output logic              wr_drop
);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  head, tail;
  logic              full, empty;

  function automatic logic [PTR_W-1:0] ptr_next(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : PTR_W'(p + 1'b1);
  endfunction

  assign full    = (fill == CNT_W'(DEPTH));
  assign empty   = (fill == '0);
  assign rd_ok   = rd_en && !empty;
  assign wr_ok   = wr_en && (!full || rd_ok);
  assign wr_drop = wr_en && !wr_ok;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[tail] <= wr_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head    <= '0;
      tail    <= '0;
      fill    <= '0;
      rd_word <= '0;
    end else begin
      if (wr_ok) tail <= ptr_next(tail);
      if (rd_ok) begin
        head    <= ptr_next(head);
        rd_word <= mem[head];
      end
      case ({wr_ok, rd_ok})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

endmodule

// File: rtl/rx_flow_level.sv
module rx_flow_level
  import rx_flow_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0] fill,
  input  logic [1:0]       sel,
  output logic [CNT_W-1:0] lvl_t,
  output logic [CNT_W-1:0] lvl_hi,
  output logic [CNT_W-1:0] lvl_lo,
  output logic             data_irq,
  output logic             at_hi,
  output logic             at_lo
);

  assign lvl_t    = CNT_W'(lvl_trig(DEPTH, sel));
  assign lvl_hi   = CNT_W'(lvl_above(DEPTH, sel));
  assign lvl_lo   = CNT_W'(lvl_below(DEPTH, sel));
  assign data_irq = (fill >= lvl_t);
  assign at_hi    = (fill >= lvl_hi);
  assign at_lo    = (fill <= lvl_lo);

endmodule

// File: rtl/rx_flow_rts.sv
module rx_flow_rts (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_en,
  input  logic req,
  input  logic irq_en,
  input  logic irq_clr,
  input  logic at_hi,
  input  logic at_lo,
  output logic rts_n,
  output logic irq,
  output logic auto_on,
  output logic pause_set,
  output logic pause_clr
);

  logic paused;

  assign auto_on   = auto_en && req;
  assign pause_set = auto_on && !paused && at_hi;
  assign pause_clr = paused && (!auto_on || at_lo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paused <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (pause_set)      paused <= 1'b1;
      else if (pause_clr) paused <= 1'b0;
      if (pause_set && irq_en) irq <= 1'b1;
      else if (irq_clr)        irq <= 1'b0;
    end
  end

  assign rts_n = auto_on ? paused : !req;

endmodule

// File: rtl/rx_flow_fifo.sv
module rx_flow_fifo #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ERR_W  = 3,
  localparam int unsigned WORD_W = DATA_W + ERR_W,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ERR_W-1:0]  wr_err,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [ERR_W-1:0]  rd_err,
  output logic [CNT_W-1:0]  fill_count,
  input  logic [1:0]        trig_sel,
  input  logic              auto_rts_en,
  input  logic              rts_req,
  input  logic              rts_irq_en,
  input  logic              rts_irq_clr,
  output logic              data_irq,
  output logic              rts_n,
  output logic              rts_irq,
  output logic              overrun
);

  logic [WORD_W-1:0] rd_word;
  logic              wr_ok, rd_ok, wr_drop;
  logic [CNT_W-1:0]  lvl_t, lvl_hi, lvl_lo;
  logic              at_hi, at_lo;
  logic              auto_on, pause_set, pause_clr;

  rx_flow_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_word({wr_err, wr_data}),
    .rd_en(rd_en), .rd_word(rd_word),
    .fill(fill_count),
    .wr_ok(wr_ok), .rd_ok(rd_ok), .wr_drop(wr_drop)
  );

  rx_flow_level #(.DEPTH(DEPTH)) u_level (
    .fill(fill_count), .sel(trig_sel),
    .lvl_t(lvl_t), .lvl_hi(lvl_hi), .lvl_lo(lvl_lo),
    .data_irq(data_irq), .at_hi(at_hi), .at_lo(at_lo)
  );

  rx_flow_rts u_rts (
    .clk(clk), .rst_n(rst_n),
    .auto_en(auto_rts_en), .req(rts_req),
    .irq_en(rts_irq_en), .irq_clr(rts_irq_clr),
    .at_hi(at_hi), .at_lo(at_lo),
    .rts_n(rts_n), .irq(rts_irq),
    .auto_on(auto_on), .pause_set(pause_set), .pause_clr(pause_clr)
  );

  assign rd_data = rd_word[DATA_W-1:0];
  assign rd_err  = rd_word[WORD_W-1:DATA_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       overrun <= 1'b0;
    else if (wr_drop) overrun <= 1'b1;
  end

endmodule

// File: rtl/rx_flow_fifo_chk.sv
module rx_flow_fifo_chk #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ERR_W  = 3,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic [ERR_W-1:0]  rd_err,
  input logic [CNT_W-1:0]  fill_count,
  input logic [CNT_W-1:0]  lvl_hi,
  input logic [CNT_W-1:0]  lvl_lo,
  input logic              auto_rts_en,
  input logic              rts_req,
  input logic              rts_irq_en,
  input logic              rts_n,
  input logic              rts_irq,
  input logic              overrun
);

  logic auto_act;
  assign auto_act = auto_rts_en && rts_req;

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill_count <= CNT_W'(DEPTH)); // R1

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_count == $past(fill_count)) || (fill_count == $past(fill_count) + 1'b1)
    || (fill_count + 1'b1 == $past(fill_count))); // R1

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && fill_count == CNT_W'(DEPTH)) |=>
    (fill_count == CNT_W'(DEPTH) && overrun)); // R6

  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && fill_count == '0) |=>
    (fill_count == '0 && $stable(rd_data) && $stable(rd_err))); // R7

  AST_PAUSE_AT_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_act && !rts_n && fill_count >= lvl_hi) |=> (rts_n || !auto_act)); // R3

  AST_HOLD_ABOVE_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_act && rts_n && fill_count > lvl_lo) |=> (rts_n || !auto_act)); // R4

  AST_MANUAL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_rts_en |-> (rts_n == !rts_req)); // R8

  AST_PAUSE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rts_n) && auto_act && $past(auto_act) && $past(rts_irq_en)) |-> rts_irq); // R9

endmodule

bind rx_flow_fifo rx_flow_fifo_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
  .rd_data(rd_data), .rd_err(rd_err), .fill_count(fill_count),
  .lvl_hi(lvl_hi), .lvl_lo(lvl_lo),
  .auto_rts_en(auto_rts_en), .rts_req(rts_req), .rts_irq_en(rts_irq_en),
  .rts_n(rts_n), .rts_irq(rts_irq), .overrun(overrun)
);

// File: tb/rx_flow_fifo_tb.sv
module rx_flow_fifo_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [2:0] wr_err = '0;
  logic [7:0] rd_data;
  logic [2:0] rd_err;
  logic [5:0] fill_count;
  logic [1:0] trig_sel = '0;
  logic       auto_rts_en = 1'b0, rts_req = 1'b0, rts_irq_en = 1'b0, rts_irq_clr = 1'b0;
  logic       data_irq, rts_n, rts_irq, overrun;

  int checks = 0;
  int fails = 0;
  int seq = 0;
  logic [10:0] model [$];

  always #4 clk = ~clk;

  rx_flow_fifo u_dut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_data(wr_data), .wr_err(wr_err),
    .rd_en(rd_en), .rd_data(rd_data), .rd_err(rd_err),
    .fill_count(fill_count), .trig_sel(trig_sel),
    .auto_rts_en(auto_rts_en), .rts_req(rts_req),
    .rts_irq_en(rts_irq_en), .rts_irq_clr(rts_irq_clr),
    .data_irq(data_irq), .rts_n(rts_n), .rts_irq(rts_irq), .overrun(overrun)
  );

  // Levels taken from the requirement text
  function automatic int trig_of(int s);
    case (s) 0: return 8; 1: return 16; 2: return 24; default: return 28; endcase
  endfunction
  function automatic int hi_of(int s);
    case (s) 0: return 16; 1: return 24; 2: return 28; default: return 32; endcase
  endfunction
  function automatic int lo_of(int s);
    case (s) 0: return 0; 1: return 8; 2: return 16; default: return 24; endcase
  endfunction

  task automatic check(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic push();
    logic [10:0] w;
    seq++;
    w = {3'(seq * 5), 8'(seq * 37 + 11)};
    @(negedge clk);
    wr_en = 1'b1; wr_err = w[10:8]; wr_data = w[7:0];
    @(negedge clk);
    wr_en = 1'b0;
    if (model.size() < 32) model.push_back(w);
  endtask

  task automatic pop(input string rq);
    logic [10:0] e;
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    if (model.size() > 0) begin
      e = model.pop_front();
      check(rq, "read word", int'({rd_err, rd_data}), int'(e));
    end
  endtask

  task automatic fill_to(input int n);
    while (model.size() < n) push();
  endtask

  task automatic drain_to(input int n, input string rq);
    while (model.size() > n) pop(rq);
  endtask

  task automatic t_reset();
    check("R10", "count", int'(fill_count), 0);
    check("R10", "rd_data", int'(rd_data), 0);
    check("R10", "rd_err", int'(rd_err), 0);
    check("R10", "data_irq", int'(data_irq), 0);
    check("R10", "rts_irq", int'(rts_irq), 0);
    check("R10", "overrun", int'(overrun), 0);
    check("R10", "rts_n", int'(rts_n), 1);
  endtask

  task automatic t_order();
    for (int i = 0; i < 5; i++) push();
    check("R1", "count after 5 writes", int'(fill_count), 5);
    pop("R11");
    check("R11", "count after read", int'(fill_count), 4);
    drain_to(0, "R1");
    check("R1", "count drained", int'(fill_count), 0);
  endtask

  task automatic t_trigger();
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      fill_to(trig_of(s) - 1);
      settle();
      check("R2", "data_irq below level", int'(data_irq), 0);
      push();
      check("R2", "data_irq at level", int'(data_irq), 1);
      drain_to(0, "R1");
    end
  endtask

  task automatic t_hyst(input int s);
    trig_sel = 2'(s);
    auto_rts_en = 1'b1; rts_req = 1'b1;
    fill_to(hi_of(s) - 1);
    settle();
    check("R3", "rts_n below upper step", int'(rts_n), 0);
    push();
    settle();
    check("R3", "rts_n at upper step", int'(rts_n), 1);
    if (hi_of(s) < 32) begin
      fill_to(hi_of(s) + 3);
      check("R5", "count while paused", int'(fill_count), hi_of(s) + 3);
    end
    drain_to(lo_of(s) + 1, "R1");
    settle();
    check("R4", "rts_n above lower step", int'(rts_n), 1);
    pop("R1");
    settle();
    check("R4", "rts_n at lower step", int'(rts_n), 0);
    drain_to(0, "R1");
    auto_rts_en = 1'b0; rts_req = 1'b0;
  endtask

  task automatic t_full();
    trig_sel = 2'd3;
    fill_to(32);
    check("R6", "overrun before drop", int'(overrun), 0);
    push();
    check("R6", "count after drop", int'(fill_count), 32);
    check("R6", "overrun after drop", int'(overrun), 1);
    drain_to(0, "R6");
    check("R6", "overrun sticky", int'(overrun), 1);
  endtask

  task automatic t_empty();
    int held;
    push();
    pop("R11");
    held = int'({rd_err, rd_data});
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    check("R7", "count after empty read", int'(fill_count), 0);
    check("R7", "read word held", int'({rd_err, rd_data}), held);
  endtask

  task automatic t_manual();
    trig_sel = 2'd0;
    auto_rts_en = 1'b0; rts_req = 1'b1;
    fill_to(20);
    settle();
    check("R8", "manual rts_n req=1", int'(rts_n), 0);
    rts_req = 1'b0;
    settle();
    check("R8", "manual rts_n req=0", int'(rts_n), 1);
    auto_rts_en = 1'b1;
    settle();
    check("R8", "auto without req", int'(rts_n), 1);
    rts_req = 1'b1;
    settle(); settle();
    check("R8", "auto started pauses", int'(rts_n), 1);
    auto_rts_en = 1'b0;
    settle();
    check("R8", "auto off follows req", int'(rts_n), 0);
    rts_req = 1'b0;
    drain_to(0, "R1");
  endtask

  task automatic t_irq();
    trig_sel = 2'd0;
    rts_irq_en = 1'b1; auto_rts_en = 1'b1; rts_req = 1'b1;
    fill_to(16);
    settle();
    check("R9", "irq on pause", int'(rts_irq), 1);
    settle(); settle();
    check("R9", "irq held", int'(rts_irq), 1);
    @(negedge clk); rts_irq_clr = 1'b1;
    @(negedge clk); rts_irq_clr = 1'b0;
    check("R9", "irq cleared", int'(rts_irq), 0);
    drain_to(0, "R1");
    rts_irq_en = 1'b0;
    settle();
    fill_to(16);
    settle();
    check("R9", "rts_n paused irq off", int'(rts_n), 1);
    check("R9", "no irq when disabled", int'(rts_irq), 0);
    drain_to(0, "R1");
    auto_rts_en = 1'b0; rts_req = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    t_reset();
    t_order();
    t_trigger();
    t_hyst(0);
    t_hyst(1);
    t_hyst(2);
    t_hyst(3);
    t_empty();
    t_manual();
    t_irq();
    t_full();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog run did not finish actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule